// File: doc/BRIEF.md
# AUX Reply Status Classifier

This block judges the outcome of one auxiliary-channel transaction after the receiver has finished with the line. The controller pulses a start strobe. The block then waits for the receiver's completion flag. When the flag arrives, it weighs the receiver's status flags against the stored reply. A hot-plug disconnect outranks every other condition. A receive timeout comes next, then any line error, then an empty reply. Only when none of these apply does the block decode the reply code and map it to an outcome.

The reply code is the upper nibble of the first byte in the receive buffer. It maps onto acknowledge, not-acknowledge and defer, at either the AUX level or the I2C level. For an acknowledge, the block reads the payload bytes that follow the code byte and streams them out one per cycle. It does this only when the payload fits the caller's buffer size; a payload that does not fit is rejected. If completion never arrives, a programmable wait counter ends the transaction with a timeout. The final outcome and the payload count stay on the outputs, with a valid strobe, until the next start.

Top module: `aux_reply_classifier`

## Requirements
- R1: While waiting for completion, an asserted hpd_discon_i produces result 7 (disconnect) on the next cycle. It does so regardless of done_i and of every other flag.
- R2: When done_i is seen and there is no disconnect, either rx_timeout_i or rx_timeout_state_i produces result 6 (timeout). This holds even when receive error flags are also set.
- R3: With no disconnect and no timeout flag, any set bit of rx_err_i produces result 5 (invalid). The bits are: bit0 invalid stop, bit1 no detect, bit2 invalid high, bit3 invalid low.
- R4: A reply_cnt_i of 0 with no other fault produces result 5 (invalid).
- R5: rx_min_cnt_viol_i has no effect on result_o, data_cnt_o or the streamed data.
- R6: The reply code is rd_data_i[7:4] read at address 0. The mapping is: code 0 gives result 0 (AUX ACK), 1 gives 1 (AUX NACK), 2 gives 2 (AUX DEFER), 4 gives 3 (I2C NACK), 8 gives 4 (I2C DEFER), and any other code gives 5 (invalid).
- R7: On an acknowledge whose payload fits, data_cnt_o equals reply_cnt_i-1. Buffer bytes 1 to reply_cnt_i-1 appear in order on data_o, one per cycle, with data_valid_o high. result_valid_o rises on the cycle after the last byte, or on the cycle after completion if there is no payload. A payload equal to buf_size_i fits.
- R8: On an acknowledge with reply_cnt_i-1 greater than buf_size_i, the result is 8 (buffer overflow). No byte is streamed and data_cnt_o is 0. Every result other than 0 also gives data_cnt_o of 0.
- R9: If done_i stays low, result 6 appears on the cycle after the (timeout_limit_i+1)-th wait cycle. A done_i that arrives on that last wait cycle still wins over the expiry.
- R10: result_o, data_cnt_o and result_valid_o hold until start_i. A start clears result_valid_o on the next cycle.
- R11: After reset, result_valid_o and data_valid_o are low and rd_addr_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begins a new transaction and clears the held result |
| timeout_limit_i | input | TW | Wait-cycle limit for completion |
| done_i | input | 1 | Receiver completion flag |
| hpd_discon_i | input | 1 | Hot-plug disconnect flag |
| rx_timeout_i | input | 1 | Receive timeout flag |
| rx_timeout_state_i | input | 1 | Receive timeout state flag |
| rx_err_i | input | 4 | Line error flags (stop, detect, high, low) |
| rx_min_cnt_viol_i | input | 1 | Minimum-count violation flag, ignored |
| reply_cnt_i | input | CW | Reply byte count, code byte included |
| buf_size_i | input | CW | Caller buffer size in bytes |
| rd_addr_o | output | CW | Receive buffer read address |
| rd_data_i | input | 8 | Receive buffer read data, combinational |
| result_o | output | 4 | Encoded outcome |
| result_valid_o | output | 1 | Outcome is final |
| data_cnt_o | output | CW | Number of valid payload bytes |
| data_o | output | 8 | Streamed payload byte |
| data_valid_o | output | 1 | data_o carries a payload byte |

## Verification
The assertions assume a few things about the inputs. timeout_limit_i and buf_size_i stay constant from start_i until the result is valid. The receive buffer answers combinationally on rd_data_i. Status flags are examined only on the cycle where done_i or hpd_discon_i is first seen. The bench respects these assumptions: it sets the limit, size and buffer contents before each start, and it raises the flags together with done_i for exactly one wait cycle. It then sweeps every flag combination and every code against several counts and buffer sizes.

// File: rtl/aux_reply_pkg.sv
package aux_reply_pkg;
  typedef enum logic [3:0] {
    RES_ACK       = 4'd0,
    RES_NACK      = 4'd1,
    RES_DEFER     = 4'd2,
    RES_I2C_NACK  = 4'd3,
    RES_I2C_DEFER = 4'd4,
    RES_INVALID   = 4'd5,
    RES_TIMEOUT   = 4'd6,
    RES_DISCON    = 4'd7,
    RES_OVERFLOW  = 4'd8
  } aux_result_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_STREAM,
    ST_DONE
  } aux_state_e;
endpackage

// File: rtl/aux_code_decode.sv
module aux_code_decode
  import aux_reply_pkg::*;
(
  input  logic [3:0]  code_i,
  output aux_result_e res_o
);
  always_comb begin
    unique case (code_i)
      4'd0:    res_o = RES_ACK;
      4'd1:    res_o = RES_NACK;
      4'd2:    res_o = RES_DEFER;
      4'd4:    res_o = RES_I2C_NACK;
      4'd8:    res_o = RES_I2C_DEFER;
      default: res_o = RES_INVALID;
    endcase
  end

  always_comb begin
    if (code_i inside {4'd3, 4'd5, 4'd6, 4'd7, [4'd9:4'd15]})
      assert_bad_code_invalid_R6: assert (res_o == RES_INVALID);
  end
endmodule

// File: rtl/aux_outcome_prio.sv
module aux_outcome_prio
  import aux_reply_pkg::*;
(
  input  logic        hpd_i,
  input  logic        tmo_i,
  input  logic [3:0]  rx_err_i,
  input  logic        cnt_zero_i,
  input  logic        overflow_i,
  input  aux_result_e code_res_i,
  output aux_result_e res_o
);
  always_comb begin
    if (hpd_i)                                  res_o = RES_DISCON;
    else if (tmo_i)                             res_o = RES_TIMEOUT;
    else if (|rx_err_i)                         res_o = RES_INVALID;
    else if (cnt_zero_i)                        res_o = RES_INVALID;
    else if (code_res_i == RES_ACK && overflow_i) res_o = RES_OVERFLOW;
    else                                        res_o = code_res_i;
  end
endmodule

// File: rtl/aux_wait_timer.sv
module aux_wait_timer #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          run_i,
  input  logic [TW-1:0] limit_i,
  output logic          expired_o
);
  logic [TW-1:0] cnt_q;

  assign expired_o = run_i && (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clear_i)             cnt_q <= '0;
    else if (run_i && !expired_o) cnt_q <= cnt_q + 1'b1;
  end

  // limit is held stable for a whole wait
  assert_timer_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= limit_i);
endmodule

// File: rtl/aux_reply_classifier.sv
module aux_reply_classifier
  import aux_reply_pkg::*;
#(
  parameter int TW = 16,
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [TW-1:0] timeout_limit_i,
  input  logic          done_i,
  input  logic          hpd_discon_i,
  input  logic          rx_timeout_i,
  input  logic          rx_timeout_state_i,
  input  logic [3:0]    rx_err_i,
  input  logic          rx_min_cnt_viol_i,
  input  logic [CW-1:0] reply_cnt_i,
  input  logic [CW-1:0] buf_size_i,
  output logic [CW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i,
  output logic [3:0]    result_o,
  output logic          result_valid_o,
  output logic [CW-1:0] data_cnt_o,
  output logic [7:0]    data_o,
  output logic          data_valid_o
);
  aux_state_e    state_q, state_d;
  aux_result_e   res_q, res_d, code_res, prio_res;
  logic [CW-1:0] dcnt_q, dcnt_d, idx_q, idx_d, ndata;
  logic          expired, overflow, min_viol_unused;

  assign min_viol_unused = rx_min_cnt_viol_i;
  assign ndata    = reply_cnt_i - 1'b1;
  assign overflow = ndata > buf_size_i;

  aux_code_decode u_dec (
    .code_i (rd_data_i[7:4]),
    .res_o  (code_res)
  );

  aux_outcome_prio u_prio (
    .hpd_i      (hpd_discon_i),
    .tmo_i      (rx_timeout_i | rx_timeout_state_i),
    .rx_err_i   (rx_err_i),
    .cnt_zero_i (reply_cnt_i == '0),
    .overflow_i (overflow),
    .code_res_i (code_res),
    .res_o      (prio_res)
  );

  aux_wait_timer #(.TW(TW)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (start_i),
    .run_i     (state_q == ST_WAIT),
    .limit_i   (timeout_limit_i),
    .expired_o (expired)
  );

  always_comb begin
    state_d = state_q;
    res_d   = res_q;
    dcnt_d  = dcnt_q;
    idx_d   = idx_q;
    if (start_i) begin
      state_d = ST_WAIT;
      dcnt_d  = '0;
      idx_d   = '0;
    end else begin
      unique case (state_q)
        ST_WAIT: begin
          if (hpd_discon_i || done_i) begin
            res_d   = prio_res;
            state_d = ST_DONE;
            if (prio_res == RES_ACK) begin
              dcnt_d = ndata;
              if (ndata != '0) begin
                state_d = ST_STREAM;
                idx_d   = CW'(1);
              end
            end
          end else if (expired) begin
            res_d   = RES_TIMEOUT;
            state_d = ST_DONE;
          end
        end
        ST_STREAM: begin
          idx_d = idx_q + 1'b1;
          if (idx_q == dcnt_q) state_d = ST_DONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      res_q   <= RES_INVALID;
      dcnt_q  <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      res_q   <= res_d;
      dcnt_q  <= dcnt_d;
      idx_q   <= idx_d;
    end
  end

  assign rd_addr_o      = (state_q == ST_STREAM) ? idx_q : '0;
  assign data_o         = rd_data_i;
  assign data_valid_o   = (state_q == ST_STREAM);
  assign result_o       = res_q;
  assign result_valid_o = (state_q == ST_DONE);
  assign data_cnt_o     = dcnt_q;

  assert_discon_first_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && hpd_discon_i && !start_i)
      |=> result_valid_o && result_o == RES_DISCON);

  assert_timeout_over_err_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !start_i && !hpd_discon_i && done_i &&
     (rx_timeout_i || rx_timeout_state_i))
      |=> result_valid_o && result_o == RES_TIMEOUT);

  assert_stream_fits_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> rd_addr_o != '0 && rd_addr_o <= buf_size_i);

  assert_nonack_no_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_o && result_o != RES_ACK) |-> data_cnt_o == '0);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_o && !start_i)
      |=> result_valid_o && $stable(result_o) && $stable(data_cnt_o));

  assert_start_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !result_valid_o && !data_valid_o);
endmodule

// File: tb/aux_reply_classifier_bench.sv
module aux_reply_classifier_bench;
  localparam int TW = 16;
  localparam int CW = 5;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [TW-1:0] timeout_limit_i = TW'(5);
  logic          done_i = 1'b0, hpd_discon_i = 1'b0;
  logic          rx_timeout_i = 1'b0, rx_timeout_state_i = 1'b0;
  logic [3:0]    rx_err_i = '0;
  logic          rx_min_cnt_viol_i = 1'b0;
  logic [CW-1:0] reply_cnt_i = '0, buf_size_i = '0;
  logic [CW-1:0] rd_addr_o;
  logic [7:0]    rd_data_i;
  logic [3:0]    result_o;
  logic          result_valid_o;
  logic [CW-1:0] data_cnt_o;
  logic [7:0]    data_o;
  logic          data_valid_o;
  logic [7:0]    mem [32];

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rd_data_i = mem[rd_addr_o];

  aux_reply_classifier #(.TW(TW), .CW(CW)) u_aux_reply_classifier (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .timeout_limit_i(timeout_limit_i),
    .done_i(done_i), .hpd_discon_i(hpd_discon_i), .rx_timeout_i(rx_timeout_i),
    .rx_timeout_state_i(rx_timeout_state_i), .rx_err_i(rx_err_i),
    .rx_min_cnt_viol_i(rx_min_cnt_viol_i), .reply_cnt_i(reply_cnt_i),
    .buf_size_i(buf_size_i), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .result_o(result_o), .result_valid_o(result_valid_o), .data_cnt_o(data_cnt_o),
    .data_o(data_o), .data_valid_o(data_valid_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_res(bit hpd, bit to, bit tos, logic [3:0] err,
                                 int cnt, int code, int bsz);
    if (hpd) return 7;
    if (to || tos) return 6;
    if (err != 0) return 5;
    if (cnt == 0) return 5;
    case (code)
      0: return (cnt - 1 > bsz) ? 8 : 0;
      1: return 1;
      2: return 2;
      4: return 3;
      8: return 4;
      default: return 5;
    endcase
  endfunction

  task automatic fill(input int code);
    mem[0] = {4'(code), 4'hA};
    for (int i = 1; i < 32; i++) mem[i] = 8'(i * 29 + code * 3 + 1);
  endtask

  task automatic begin_txn();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(!result_valid_o, "R10 start clears valid", result_valid_o, 0);
  endtask

  task automatic run_case(input bit hpd, input bit to, input bit tos,
                          input logic [3:0] err, input bit minv,
                          input int cnt, input int code, input int bsz);
    int er, nd;
    fill(code);
    reply_cnt_i = CW'(cnt);
    buf_size_i  = CW'(bsz);
    begin_txn();
    done_i = 1'b1; hpd_discon_i = hpd; rx_timeout_i = to;
    rx_timeout_state_i = tos; rx_err_i = err; rx_min_cnt_viol_i = minv;
    @(negedge clk);
    done_i = 1'b0; hpd_discon_i = 1'b0; rx_timeout_i = 1'b0;
    rx_timeout_state_i = 1'b0; rx_err_i = '0; rx_min_cnt_viol_i = 1'b0;
    er = exp_res(hpd, to, tos, err, cnt, code, bsz);
    nd = (er == 0) ? cnt - 1 : 0;
    for (int k = 1; k <= nd; k++) begin
      chk(data_valid_o && data_o == mem[k], "R7 streamed byte", data_o, mem[k]);
      @(negedge clk);
    end
    chk(!data_valid_o, "R8 no extra data", data_valid_o, 0);
    chk(result_valid_o && result_o == 4'(er),
        hpd ? "R1 disconnect" : (to || tos) ? "R2 timeout flag" :
        (err != 0) ? "R3 line error" : (cnt == 0) ? "R4 empty reply" :
        (er == 8) ? "R8 overflow" : "R6 code map (R5 min viol ignored)",
        result_o, er);
    chk(data_cnt_o == CW'(nd), "R7 data count", data_cnt_o, nd);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    fill(0);
    #(CLK_PERIOD * 2);
    @(negedge clk);
    chk(!result_valid_o && !data_valid_o && rd_addr_o == 0, "R11 reset state",
        {result_valid_o, data_valid_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!result_valid_o && !data_valid_o, "R11 idle after reset", result_valid_o, 0);

    // flag sweep: bits 3:0 err, 4 to, 5 tos, 6 hpd, 7 min viol
    for (int f = 0; f < 256; f++)
      run_case(f[6], f[4], f[5], 4'(f), f[7], 3, 0, 4);

    // code x count x size sweep
    for (int code = 0; code < 16; code++)
      for (int cnt = 0; cnt < 7; cnt++)
        for (int b = 0; b < 2; b++)
          run_case(1'b0, 1'b0, 1'b0, 4'h0, b[0], cnt, code, b ? 3 : 0);

    // R10 hold for several idle cycles
    run_case(1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 4, 0, 5);
    repeat (4) begin
      @(negedge clk);
      chk(result_valid_o && result_o == 0 && data_cnt_o == 3, "R10 held result",
          result_o, 0);
    end

    // R9 wait-counter expiry
    timeout_limit_i = TW'(5);
    begin_txn();
    repeat (5) begin
      chk(!result_valid_o, "R9 no early expiry", result_valid_o, 0);
      @(negedge clk);
    end
    chk(!result_valid_o, "R9 no early expiry", result_valid_o, 0);
    @(negedge clk);
    chk(result_valid_o && result_o == 6, "R9 expiry timeout", result_o, 6);

    // R9 done on last wait cycle wins
    fill(1);
    reply_cnt_i = CW'(1);
    begin_txn();
    repeat (5) @(negedge clk);
    done_i = 1'b1;
    @(negedge clk);
    done_i = 1'b0;
    chk(result_valid_o && result_o == 1, "R9 done beats expiry", result_o, 1);

    // R1 disconnect without done
    begin_txn();
    hpd_discon_i = 1'b1;
    @(negedge clk);
    hpd_discon_i = 1'b0;
    chk(result_valid_o && result_o == 7, "R1 disconnect before done", result_o, 7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule